// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

A synchronous static memory that takes one read or write command on every enabled clock with no idle cycles when the direction changes. Read data and write data both sit two enabled clock edges behind their command. The address bus and the data bus are therefore used in the same way for both directions, and a read may follow a write, or a write a read, on the very next clock.

Each command either loads a fresh address or continues the current burst. A continued burst steps an internal two-bit counter that wraps inside the four-word group of the loaded address. Write addresses move through two pipeline registers. A further posted-write register holds the most recent write until it is committed to the array, and reads that hit that register get the new bytes forwarded. Dropping the clock enable freezes every stage. The data bus is modelled as a separate input and output with a drive flag.

Top module: `zt_burst_sram`

## Requirements
- R1: A read command (chip selected, load/continue input low, write enable high) sampled at an enabled edge puts the word at its address on `data_o` after the second following enabled edge. `data_oe_o` is then high when `oe_n_i` is low.
- R2: A write command samples `data_i` at the second enabled edge after the command. Lane k is bits [9k+8:9k], parity bit included, and it is written only if `lane_we_n_i[k]` was low in the command cycle.
- R3: A write whose lane enables are all high leaves the addressed word unchanged.
- R4: Reads and writes may alternate on consecutive clocks. A read of an address written by any earlier command, including the command just before it, returns the new data.
- R5: With `adv_i` high after a load, each enabled edge accesses the next address. Bits [1:0] step up by one modulo 4, the upper bits stay fixed, and the direction set by the load is kept.
- R6: `adv_i` high after a deselect (chip not selected with `adv_i` low) performs no access. No word changes, and the matching data slot leaves `data_oe_o` low.
- R7: An edge with `clk_en_i` low is ignored. `data_o`, `data_oe_o` and all pipeline and burst state hold.
- R8: `data_oe_o` is low in the data slot of a write, whatever the level of `oe_n_i`.
- R9: `oe_n_i` high forces `data_oe_o` low, and the data slot of a deselect also leaves it low.
- R10: After reset `data_oe_o` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable; low ignores the edge |
| sel_n_i | input | 1 | Chip select, active low, sampled on loads |
| adv_i | input | 1 | 0 = load new address, 1 = continue burst |
| we_n_i | input | 1 | 0 = write, 1 = read, sampled on loads |
| lane_we_n_i | input | LANES | Per-lane write enables, active low |
| oe_n_i | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Word address |
| data_i | input | LANES*LANE_W | Write data, bus input side |
| data_o | output | LANES*LANE_W | Read data, bus output side |
| data_oe_o | output | 1 | Bus drive flag |

## Verification
All 64 words are first written with full lane enables and read back in sequence, which separates correct read latency from off-by-one-slot errors. Every lane-enable combination is then tried, the all-disabled case included, to tell masking from whole-word writes. Write-then-read pairs on the same address and on neighbouring addresses separate forwarding from plain array reads. Bursts from each of the four low offsets, longer bursts that wrap, aborted bursts after a deselect, stalls inserted mid-burst and blocks with output enable released cover the counter wrap, the no-op path, the hold on a stall and the drive flag.

// File: rtl/zt_pkg.sv
package zt_pkg;
  typedef enum logic [1:0] {OP_DESEL, OP_READ, OP_WRITE, OP_CONT} op_e;

  function automatic op_e classify(logic sel_n, logic adv, logic we_n);
    if (adv)       return OP_CONT;
    else if (sel_n) return OP_DESEL;
    else if (we_n)  return OP_READ;
    else            return OP_WRITE;
  endfunction
endpackage

// File: rtl/zt_cmd_seq.sv
module zt_cmd_seq #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sel_n_i,
  input  logic              adv_i,
  input  logic              we_n_i,
  input  logic [LANES-1:0]  be_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              slot_v_o,
  output logic              slot_wr_o,
  output logic [ADDR_W-1:0] slot_addr_o,
  output logic [LANES-1:0]  slot_be_o
);
  import zt_pkg::*;
  localparam int BURST_W = 2;
  localparam int HI_W    = ADDR_W - BURST_W;

  op_e                op;
  logic               act_q, wr_q;
  logic [BURST_W-1:0] lo_q, lo_nxt;
  logic [HI_W-1:0]    hi_q;

  assign op     = classify(sel_n_i, adv_i, we_n_i);
  assign lo_nxt = lo_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      wr_q        <= 1'b0;
      lo_q        <= '0;
      hi_q        <= '0;
      slot_v_o    <= 1'b0;
      slot_wr_o   <= 1'b0;
      slot_addr_o <= '0;
      slot_be_o   <= '0;
    end else if (en_i) begin
      unique case (op)
        OP_READ, OP_WRITE: begin
          act_q       <= 1'b1;
          wr_q        <= (op == OP_WRITE);
          hi_q        <= addr_i[ADDR_W-1:BURST_W];
          lo_q        <= addr_i[BURST_W-1:0];
          slot_v_o    <= 1'b1;
          slot_wr_o   <= (op == OP_WRITE);
          slot_addr_o <= addr_i;
          slot_be_o   <= ~be_n_i;
        end
        OP_DESEL: begin
          act_q     <= 1'b0;
          slot_v_o  <= 1'b0;
          slot_wr_o <= 1'b0;
        end
        default: begin
          if (act_q) begin
            lo_q        <= lo_nxt;
            slot_v_o    <= 1'b1;
            slot_wr_o   <= wr_q;
            slot_addr_o <= {hi_q, lo_nxt};
            slot_be_o   <= ~be_n_i;
          end else begin
            slot_v_o  <= 1'b0;
            slot_wr_o <= 1'b0;
          end
        end
      endcase
    end
  end

  AST_BURST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && adv_i && act_q |=> slot_v_o &&
      slot_addr_o[BURST_W-1:0] == $past(slot_addr_o[BURST_W-1:0]) + 2'd1 &&
      slot_addr_o[ADDR_W-1:BURST_W] == $past(slot_addr_o[ADDR_W-1:BURST_W])); // R5
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && adv_i && !act_q |=> !slot_v_o); // R6
endmodule

// File: rtl/zt_store.sv
module zt_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              pend_v_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [LANES-1:0]  pend_be_q;
  logic [DATA_W-1:0] pend_data_q;
  logic [DATA_W-1:0] arr_word, fwd_word;
  logic              hit;

  assign arr_word = mem_q[addr_i];
  assign hit      = pend_v_q && (pend_addr_q == addr_i);

  // posted write: captured at the data edge, committed one enabled edge later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pend_v_q <= 1'b0;
    else if (en_i) pend_v_q <= wr_i;
  end

  always_ff @(posedge clk_i) begin
    if (en_i && wr_i) begin
      pend_addr_q <= addr_i;
      pend_be_q   <= be_i;
      pend_data_q <= wdata_i;
    end
    if (en_i && rd_i) rdata_o <= fwd_word;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign fwd_word[k*LANE_W +: LANE_W] = (hit && pend_be_q[k]) ?
      pend_data_q[k*LANE_W +: LANE_W] : arr_word[k*LANE_W +: LANE_W];

    always_ff @(posedge clk_i) begin
      if (en_i && pend_v_q && pend_be_q[k])
        mem_q[pend_addr_q][k*LANE_W +: LANE_W] <= pend_data_q[k*LANE_W +: LANE_W];
    end
  end

  AST_FWD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && rd_i && hit && (&pend_be_q) |=> rdata_o == $past(pend_data_q)); // R4
endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clk_en_i,
  input  logic                    sel_n_i,
  input  logic                    adv_i,
  input  logic                    we_n_i,
  input  logic [LANES-1:0]        lane_we_n_i,
  input  logic                    oe_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] data_i,
  output logic [LANES*LANE_W-1:0] data_o,
  output logic                    data_oe_o
);
  logic              s1_v, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_be;
  logic              s2_v_q, s2_wr_q;
  logic [ADDR_W-1:0] s2_addr_q;
  logic [LANES-1:0]  s2_be_q;
  logic              out_rd_q;

  zt_cmd_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (clk_en_i),
    .sel_n_i    (sel_n_i),
    .adv_i      (adv_i),
    .we_n_i     (we_n_i),
    .be_n_i     (lane_we_n_i),
    .addr_i     (addr_i),
    .slot_v_o   (s1_v),
    .slot_wr_o  (s1_wr),
    .slot_addr_o(s1_addr),
    .slot_be_o  (s1_be)
  );

  // second address stage: its edge is the data edge for reads and writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v_q    <= 1'b0;
      s2_wr_q   <= 1'b0;
      s2_addr_q <= '0;
      s2_be_q   <= '0;
      out_rd_q  <= 1'b0;
    end else if (clk_en_i) begin
      s2_v_q    <= s1_v;
      s2_wr_q   <= s1_wr;
      s2_addr_q <= s1_addr;
      s2_be_q   <= s1_be;
      out_rd_q  <= s2_v_q && !s2_wr_q;
    end
  end

  zt_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (clk_en_i),
    .wr_i   (s2_v_q && s2_wr_q),
    .rd_i   (s2_v_q && !s2_wr_q),
    .addr_i (s2_addr_q),
    .be_i   (s2_be_q),
    .wdata_i(data_i),
    .rdata_o(data_o)
  );

  assign data_oe_o = out_rd_q && !oe_n_i;

  AST_WR_SLOT_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_i && s2_v_q && s2_wr_q |=> !data_oe_o); // R8
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> $stable(data_o) && $stable(out_rd_q) && $stable(s2_addr_q)); // R7
  AST_DESEL_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_i && !s2_v_q |=> !data_oe_o); // R9
endmodule

// File: tb/tb_zt_burst_sram.sv
module tb_zt_burst_sram;
  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, sel_n = 1'b1, adv = 1'b0, we_n = 1'b1, oe_n = 1'b0;
  logic [1:0]    be_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0, dout;
  logic          doe;

  always #5 clk = ~clk;

  zt_burst_sram dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(en), .sel_n_i(sel_n), .adv_i(adv),
    .we_n_i(we_n), .lane_we_n_i(be_n), .oe_n_i(oe_n), .addr_i(addr),
    .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  int total = 0, fails = 0;
  bit done = 0;
  string tag = "R1";
  logic g_oe_n = 1'b0;

  // reference model
  logic [DW-1:0] ref_mem [64];
  logic          b_act = 0, b_wr = 0;
  logic [AW-1:0] b_base = '0;
  logic [1:0]    b_off = '0;
  logic          m1v = 0, m1w = 0, m2v = 0, m2w = 0;
  logic [AW-1:0] m1a = '0, m2a = '0;
  logic [1:0]    m1b = '0, m2b = '0;
  logic          exp_rd = 0;
  logic [DW-1:0] exp_d = '0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic e, input logic s_n, input logic a, input logic w_n,
                      input logic [1:0] bn, input logic [AW-1:0] ad);
    logic [DW-1:0] prev_d;
    logic          prev_oe;
    logic          nv, nw;
    logic [AW-1:0] na;
    en = e; sel_n = s_n; adv = a; we_n = w_n; be_n = bn; addr = ad; oe_n = g_oe_n;
    din = DW'($urandom);
    prev_d = dout; prev_oe = doe;
    @(posedge clk);
    if (e) begin
      if (m2v && m2w) begin
        for (int k = 0; k < 2; k++)
          if (m2b[k]) ref_mem[m2a][k*9 +: 9] = din[k*9 +: 9];
      end
      exp_rd = m2v && !m2w;
      if (exp_rd) exp_d = ref_mem[m2a];
      nv = 0; nw = 0; na = '0;
      if (!a && !s_n) begin
        b_act = 1; b_wr = !w_n; b_base = ad; b_off = 0;
        nv = 1; nw = !w_n; na = ad;
      end else if (!a) begin
        b_act = 0;
      end else if (b_act) begin
        b_off = b_off + 2'd1;
        nv = 1; nw = b_wr; na = {b_base[AW-1:2], 2'(b_base[1:0] + b_off)};
      end
      m2v = m1v; m2w = m1w; m2a = m1a; m2b = m1b;
      m1v = nv;  m1w = nw;  m1a = na;  m1b = ~bn;
    end
    #2;
    if (!e) begin
      check(dout === prev_d && doe === prev_oe, "R7 stall", {dout[DW-1:1], doe}, {prev_d[DW-1:1], prev_oe});
    end else if (exp_rd && !g_oe_n) begin
      check(doe === 1'b1, "R1 drive", DW'(doe), DW'(1));
      check(dout === exp_d, tag, dout, exp_d);
    end else begin
      check(doe === 1'b0, (m2v === 1'b1 || exp_rd) ? (exp_rd ? "R9 oe" : "R8 wslot") : "R9 idle",
            DW'(doe), DW'(0));
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] bn); step(1, 0, 0, 0, bn, a); endtask
  task automatic rd(input logic [AW-1:0] a); step(1, 0, 0, 1, 2'b11, a); endtask
  task automatic cont(input logic [1:0] bn); step(1, 1, 1, 0, bn, '0); endtask
  task automatic desel(); step(1, 1, 0, 1, 2'b11, '0); endtask
  task automatic stall(); step(0, 0, 0, 0, 2'b00, '0); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    #1;
    check(doe === 1'b0, "R10 reset", DW'(doe), DW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    // R10: continue right after reset is a no-op
    cont(2'b00); cont(2'b00); desel(); desel();
    tag = "R2";
    for (int a = 0; a < 64; a++) wr(AW'(a), 2'b00);
    desel(); desel();
    tag = "R1";
    for (int a = 0; a < 64; a++) rd(AW'(a));
    desel(); desel();
    tag = "R3";
    for (int b = 0; b < 4; b++) begin
      wr(AW'(10 + b), 2'(b)); desel(); desel(); rd(AW'(10 + b)); desel(); desel();
    end
    tag = "R4";
    for (int a = 0; a < 64; a += 3) begin
      wr(AW'(a), 2'(a % 3)); rd(AW'(a)); rd(AW'(a + 1)); wr(AW'(a + 1), 2'b00); rd(AW'(a + 1));
    end
    for (int a = 0; a < 8; a++) begin
      wr(AW'(a), 2'b00); wr(AW'(a + 1), 2'b10); rd(AW'(a)); rd(AW'(a + 1));
    end
    desel(); desel();
    tag = "R5";
    for (int o = 0; o < 4; o++) begin
      wr(AW'(20 + o), 2'b00); cont(2'b00); cont(2'(o)); cont(2'b00);
      rd(AW'(20 + o)); cont(2'b11); cont(2'b11); cont(2'b11); cont(2'b11); cont(2'b11);
    end
    desel(); desel();
    tag = "R6";
    desel(); cont(2'b00); cont(2'b00); cont(2'b00); desel(); desel();
    for (int a = 0; a < 64; a++) rd(AW'(a));
    desel(); desel();
    tag = "R7";
    wr(AW'(40), 2'b00); stall(); cont(2'b00); stall(); stall(); cont(2'b01);
    rd(AW'(40)); stall(); cont(2'b11); stall(); cont(2'b11); cont(2'b11); stall(); desel(); stall(); desel();
    tag = "R9";
    g_oe_n = 1'b1;
    rd(AW'(1)); rd(AW'(2)); rd(AW'(3)); desel(); desel();
    g_oe_n = 1'b0;
    tag = "R8";
    rd(AW'(5)); wr(AW'(6), 2'b00); rd(AW'(6)); wr(AW'(5), 2'b01); rd(AW'(5)); desel(); desel();
    finish_run();
  end
endmodule